// File: doc/BRIEF.md
# Predicated Dual-Issue Pairing Unit

This unit sits at the issue point of a lockstep SIMD core. It looks at two consecutive decoded instructions from one warp, the older in slot A and the younger in slot B, and decides on every cycle whether both can go out together or only the older one. The older instruction always leaves when it is valid. The younger joins it only when it reads nothing the older one writes, including the predicate that guards it. The two must also use different execution-unit classes, and they must not write the same register in any lane where both are active.

The destination check looks at the predicates. Each guard selects the lanes of one predicate register, either as stored or inverted, and the unit derives a 32-lane active mask for each slot. The two arms of a branch that has been compiled into complementary guards (`@P` / `@!P`) can therefore write the same register in the same cycle, because their lanes never meet. When the younger instruction is held back, a hold flag tells the front end to move it into the older slot on the next cycle. All outputs are registered.

Top module: `warp_pair_issue`

## Requirements
- R1: While rst_ni is low all outputs are zero. The issue flag of slot A equals slot A's valid input sampled at the previous rising clock edge, so every decision appears one cycle after its inputs.
- R2: Slot B does not issue if an enabled source of slot B (src0 gated by src_en bit 0, src1 gated by bit 1) equals slot A's destination while slot A's write-enable is high. A disabled source is never compared.
- R3: Slot B does not issue if slot A sets a predicate (pset high) whose index equals slot B's guard index, unless that index is 7, which is the constant-true predicate and is never produced.
- R4: Slot B does not issue if both slots carry the same 2-bit unit class.
- R5: The active mask of a slot is bit `p*32+l` of the predicate file for predicate p (0..6) and lane l. For index 7 the mask is all ones. When the slot's negate flag is set, the whole mask is inverted.
- R6: When both slots write the same destination register, slot B is blocked only if the two active masks share at least one lane. Disjoint masks, including complementary guards on one predicate and masks that are empty, do not block.
- R7: A slot whose write-enable is low never causes a destination conflict.
- R8: hold_o is high exactly when both slots were valid and slot B did not issue.
- R9: Each slot's write mask equals its active mask ANDed with its write-enable when the slot issues, and is zero otherwise.
- R10: Slot B never issues unless slot A is valid in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pred_file_i | input | 224 | Predicates 0..6, 32 lanes each, predicate p lane l at bit p*32+l |
| a_valid_i | input | 1 | Slot A (older) holds an instruction |
| a_dst_i | input | 6 | Slot A destination register |
| a_wr_en_i | input | 1 | Slot A writes its destination |
| a_unit_i | input | 2 | Slot A execution-unit class |
| a_pidx_i | input | 3 | Slot A guard predicate index |
| a_pneg_i | input | 1 | Slot A guard inversion |
| a_pset_i | input | 1 | Slot A writes a predicate register |
| a_pdst_i | input | 3 | Predicate written by slot A |
| b_valid_i | input | 1 | Slot B (younger) holds an instruction |
| b_dst_i | input | 6 | Slot B destination register |
| b_wr_en_i | input | 1 | Slot B writes its destination |
| b_src0_i | input | 6 | Slot B first source register |
| b_src1_i | input | 6 | Slot B second source register |
| b_src_en_i | input | 2 | Slot B source used flags |
| b_unit_i | input | 2 | Slot B execution-unit class |
| b_pidx_i | input | 3 | Slot B guard predicate index |
| b_pneg_i | input | 1 | Slot B guard inversion |
| a_issue_o | output | 1 | Slot A issued |
| b_issue_o | output | 1 | Slot B issued with slot A |
| hold_o | output | 1 | Slot B held, to move to slot A next cycle |
| a_wmask_o | output | 32 | Slot A per-lane write mask |
| b_wmask_o | output | 32 | Slot B per-lane write mask |

## Verification
The assertions take it that all inputs are known and stable across each rising edge. They also take it that the predicate file already holds the values the two guards should see in this cycle. Any write by slot A reaches the file only after the pair has left. The stimulus drives every input on the falling edge and holds it for a full cycle. Register, unit and predicate indices are drawn from small ranges so that address matches, unit clashes and shared guards come up often. Directed cases add complementary guards, empty masks and the constant-true predicate.

// File: rtl/pair_issue_pkg.sv
package pair_issue_pkg;
  localparam int unsigned LANES_D  = 32;
  localparam int unsigned REG_W_D  = 6;
  localparam int unsigned PRED_W_D = 3;
  localparam int unsigned UNIT_W_D = 2;
  localparam int unsigned NSRC     = 2;
endpackage

// File: rtl/pred_lane_mask.sv
module pred_lane_mask #(
  parameter int unsigned LANES  = 32,
  parameter int unsigned PRED_W = 3,
  localparam int unsigned NPRED = 2 ** PRED_W,
  localparam int unsigned PF_W  = (NPRED - 1) * LANES
) (
  input  logic [PF_W-1:0]   pred_file_i,
  input  logic [PRED_W-1:0] idx_i,
  input  logic              neg_i,
  output logic [LANES-1:0]  mask_o
);
  logic [LANES-1:0] raw;
  always_comb begin
    raw = '1;  // top index is the constant-true predicate
    if (idx_i != PRED_W'(NPRED - 1)) raw = pred_file_i[int'(idx_i) * LANES +: LANES];
    mask_o = raw ^ {LANES{neg_i}};
  end
endmodule

// File: rtl/pair_hazard.sv
module pair_hazard
  import pair_issue_pkg::*;
#(
  parameter int unsigned REG_W  = 6,
  parameter int unsigned PRED_W = 3,
  parameter int unsigned UNIT_W = 2,
  localparam int unsigned NPRED = 2 ** PRED_W
) (
  input  logic [REG_W-1:0]           a_dst_i,
  input  logic                       a_wr_en_i,
  input  logic [UNIT_W-1:0]          a_unit_i,
  input  logic                       a_pset_i,
  input  logic [PRED_W-1:0]          a_pdst_i,
  input  logic [NSRC-1:0][REG_W-1:0] b_src_i,
  input  logic [NSRC-1:0]            b_src_en_i,
  input  logic [UNIT_W-1:0]          b_unit_i,
  input  logic [PRED_W-1:0]          b_pidx_i,
  output logic                       raw_o,
  output logic                       pdep_o,
  output logic                       unit_o
);
  logic [NSRC-1:0] hit;
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign hit[g] = b_src_en_i[g] & a_wr_en_i & (b_src_i[g] == a_dst_i);
  end
  assign raw_o  = |hit;
  assign pdep_o = a_pset_i & (a_pdst_i == b_pidx_i) & (b_pidx_i != PRED_W'(NPRED - 1));
  assign unit_o = (a_unit_i == b_unit_i);
endmodule

// File: rtl/dst_overlap.sv
module dst_overlap #(
  parameter int unsigned LANES = 32,
  parameter int unsigned REG_W = 6
) (
  input  logic [REG_W-1:0] a_dst_i,
  input  logic             a_wr_en_i,
  input  logic [LANES-1:0] a_mask_i,
  input  logic [REG_W-1:0] b_dst_i,
  input  logic             b_wr_en_i,
  input  logic [LANES-1:0] b_mask_i,
  output logic             conflict_o
);
  assign conflict_o = a_wr_en_i & b_wr_en_i & (a_dst_i == b_dst_i) & (|(a_mask_i & b_mask_i));
endmodule

// File: rtl/warp_pair_issue.sv
module warp_pair_issue
  import pair_issue_pkg::*;
#(
  parameter int unsigned LANES  = LANES_D,
  parameter int unsigned REG_W  = REG_W_D,
  parameter int unsigned PRED_W = PRED_W_D,
  parameter int unsigned UNIT_W = UNIT_W_D,
  localparam int unsigned NPRED = 2 ** PRED_W,
  localparam int unsigned PF_W  = (NPRED - 1) * LANES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PF_W-1:0]   pred_file_i,
  input  logic              a_valid_i,
  input  logic [REG_W-1:0]  a_dst_i,
  input  logic              a_wr_en_i,
  input  logic [UNIT_W-1:0] a_unit_i,
  input  logic [PRED_W-1:0] a_pidx_i,
  input  logic              a_pneg_i,
  input  logic              a_pset_i,
  input  logic [PRED_W-1:0] a_pdst_i,
  input  logic              b_valid_i,
  input  logic [REG_W-1:0]  b_dst_i,
  input  logic              b_wr_en_i,
  input  logic [REG_W-1:0]  b_src0_i,
  input  logic [REG_W-1:0]  b_src1_i,
  input  logic [NSRC-1:0]   b_src_en_i,
  input  logic [UNIT_W-1:0] b_unit_i,
  input  logic [PRED_W-1:0] b_pidx_i,
  input  logic              b_pneg_i,
  output logic              a_issue_o,
  output logic              b_issue_o,
  output logic              hold_o,
  output logic [LANES-1:0]  a_wmask_o,
  output logic [LANES-1:0]  b_wmask_o
);
  logic [LANES-1:0] a_act, b_act;
  logic raw, pdep, unit_clash, dst_clash, pair_ok;
  logic [NSRC-1:0][REG_W-1:0] b_src;

  assign b_src = {b_src1_i, b_src0_i};

  pred_lane_mask #(.LANES(LANES), .PRED_W(PRED_W)) u_mask_a (
    .pred_file_i(pred_file_i), .idx_i(a_pidx_i), .neg_i(a_pneg_i), .mask_o(a_act)
  );
  pred_lane_mask #(.LANES(LANES), .PRED_W(PRED_W)) u_mask_b (
    .pred_file_i(pred_file_i), .idx_i(b_pidx_i), .neg_i(b_pneg_i), .mask_o(b_act)
  );

  pair_hazard #(.REG_W(REG_W), .PRED_W(PRED_W), .UNIT_W(UNIT_W)) u_hazard (
    .a_dst_i(a_dst_i), .a_wr_en_i(a_wr_en_i), .a_unit_i(a_unit_i),
    .a_pset_i(a_pset_i), .a_pdst_i(a_pdst_i),
    .b_src_i(b_src), .b_src_en_i(b_src_en_i), .b_unit_i(b_unit_i), .b_pidx_i(b_pidx_i),
    .raw_o(raw), .pdep_o(pdep), .unit_o(unit_clash)
  );

  dst_overlap #(.LANES(LANES), .REG_W(REG_W)) u_dst (
    .a_dst_i(a_dst_i), .a_wr_en_i(a_wr_en_i), .a_mask_i(a_act),
    .b_dst_i(b_dst_i), .b_wr_en_i(b_wr_en_i), .b_mask_i(b_act),
    .conflict_o(dst_clash)
  );

  assign pair_ok = a_valid_i & b_valid_i & ~raw & ~pdep & ~unit_clash & ~dst_clash;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_issue_o <= 1'b0;
      b_issue_o <= 1'b0;
      hold_o    <= 1'b0;
      a_wmask_o <= '0;
      b_wmask_o <= '0;
    end else begin
      a_issue_o <= a_valid_i;
      b_issue_o <= pair_ok;
      hold_o    <= a_valid_i & b_valid_i & ~pair_ok;
      a_wmask_o <= a_act & {LANES{a_valid_i & a_wr_en_i}};
      b_wmask_o <= b_act & {LANES{pair_ok & b_wr_en_i}};
    end
  end
endmodule

// File: rtl/warp_pair_issue_chk.sv
module warp_pair_issue_chk #(
  parameter int unsigned LANES  = 32,
  parameter int unsigned REG_W  = 6,
  parameter int unsigned UNIT_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              a_valid_i,
  input logic [REG_W-1:0]  a_dst_i,
  input logic              a_wr_en_i,
  input logic [UNIT_W-1:0] a_unit_i,
  input logic              b_valid_i,
  input logic [REG_W-1:0]  b_dst_i,
  input logic              b_wr_en_i,
  input logic [REG_W-1:0]  b_src0_i,
  input logic [1:0]        b_src_en_i,
  input logic [UNIT_W-1:0] b_unit_i,
  input logic              a_issue_o,
  input logic              b_issue_o,
  input logic              hold_o,
  input logic [LANES-1:0]  a_wmask_o,
  input logic [LANES-1:0]  b_wmask_o
);
  logic seen;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) seen <= 1'b0;
    else         seen <= 1'b1;

  p_latency_r1: assert property (@(posedge clk_i) disable iff (!rst_ni || !seen)
    a_issue_o == $past(a_valid_i));
  p_src0_dep_r2: assert property (@(posedge clk_i) disable iff (!rst_ni || !seen)
    b_issue_o |-> !$past(b_src_en_i[0] && a_wr_en_i && (b_src0_i == a_dst_i)));
  p_unit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni || !seen)
    b_issue_o |-> $past(a_unit_i) != $past(b_unit_i));
  p_lane_disjoint_r6: assert property (@(posedge clk_i) disable iff (!rst_ni || !seen)
    (b_issue_o && $past(a_dst_i == b_dst_i)) |-> ((a_wmask_o & b_wmask_o) == '0));
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni || !seen)
    hold_o |-> (a_issue_o && !b_issue_o));
  p_hold_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni || !seen)
    (a_issue_o && !b_issue_o && $past(b_valid_i)) |-> hold_o);
  p_mask_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !b_issue_o |-> (b_wmask_o == '0));
  p_mask_nowr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni || !seen)
    !$past(b_wr_en_i) |-> (b_wmask_o == '0));
  p_needs_a_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_issue_o |-> a_issue_o);
endmodule

bind warp_pair_issue warp_pair_issue_chk #(.LANES(LANES), .REG_W(REG_W), .UNIT_W(UNIT_W)) chk_i (.*);

// File: tb/warp_pair_issue_tb_top.sv
module warp_pair_issue_tb_top;
  localparam int LANES = 32;
  localparam int PF_W  = 7 * LANES;

  logic clk_i = 1'b0;
  logic rst_ni;
  logic [PF_W-1:0] pred_file_i;
  logic a_valid_i, a_wr_en_i, a_pneg_i, a_pset_i;
  logic [5:0] a_dst_i;
  logic [1:0] a_unit_i;
  logic [2:0] a_pidx_i, a_pdst_i;
  logic b_valid_i, b_wr_en_i, b_pneg_i;
  logic [5:0] b_dst_i, b_src0_i, b_src1_i;
  logic [1:0] b_src_en_i, b_unit_i;
  logic [2:0] b_pidx_i;
  logic a_issue_o, b_issue_o, hold_o;
  logic [LANES-1:0] a_wmask_o, b_wmask_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  warp_pair_issue dut_i (.*);

  function automatic logic [LANES-1:0] act(input logic [2:0] idx, input logic neg);
    logic [LANES-1:0] m;
    m = (idx == 3'd7) ? '1 : pred_file_i[idx * LANES +: LANES];
    return neg ? ~m : m;
  endfunction

  task automatic chk(input string tag, input logic [LANES-1:0] got, input logic [LANES-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic clear_in();
    pred_file_i = '0;
    a_valid_i = 0; a_dst_i = 0; a_wr_en_i = 0; a_unit_i = 0; a_pidx_i = 3'd7;
    a_pneg_i = 0; a_pset_i = 0; a_pdst_i = 0;
    b_valid_i = 0; b_dst_i = 0; b_wr_en_i = 0; b_src0_i = 0; b_src1_i = 0;
    b_src_en_i = 0; b_unit_i = 1; b_pidx_i = 3'd7; b_pneg_i = 0;
  endtask

  // inputs already driven on a falling edge; compute, clock, compare
  task automatic step(input string tag);
    logic [LANES-1:0] am, bm;
    logic raw, pdep, ok;
    am   = act(a_pidx_i, a_pneg_i);
    bm   = act(b_pidx_i, b_pneg_i);
    raw  = a_wr_en_i && ((b_src_en_i[0] && b_src0_i == a_dst_i) ||
                         (b_src_en_i[1] && b_src1_i == a_dst_i));
    pdep = a_pset_i && a_pdst_i == b_pidx_i && b_pidx_i != 3'd7;
    ok   = a_valid_i && b_valid_i && !raw && !pdep && a_unit_i != b_unit_i &&
           !(a_wr_en_i && b_wr_en_i && a_dst_i == b_dst_i && (am & bm) != '0);
    @(posedge clk_i);
    @(negedge clk_i);
    chk({tag, " R1 a_issue"}, LANES'(a_issue_o), LANES'(a_valid_i));
    chk({tag, " R10 b_issue"}, LANES'(b_issue_o), LANES'(ok));
    chk({tag, " R8 hold"}, LANES'(hold_o), LANES'(a_valid_i && b_valid_i && !ok));
    chk({tag, " R9 a_wmask"}, a_wmask_o, (a_valid_i && a_wr_en_i) ? am : '0);
    chk({tag, " R9 b_wmask"}, b_wmask_o, (ok && b_wr_en_i) ? bm : '0);
  endtask

  task automatic base_pair();
    clear_in();
    a_valid_i = 1; a_wr_en_i = 1; a_dst_i = 6'd4; a_unit_i = 2'd0;
    b_valid_i = 1; b_wr_en_i = 1; b_dst_i = 6'd9; b_unit_i = 2'd1;
    b_src0_i = 6'd1; b_src1_i = 6'd2; b_src_en_i = 2'b11;
    pred_file_i[0 +: LANES] = 32'h5555_AAAA;
    pred_file_i[2 * LANES +: LANES] = 32'h0F0F_F0F0;
  endtask

  initial begin
    clear_in();
    rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk("R1 reset issue", LANES'({a_issue_o, b_issue_o, hold_o}), '0);
    chk("R1 reset masks", a_wmask_o | b_wmask_o, '0);
    rst_ni = 1'b1;

    clear_in(); a_valid_i = 1; a_wr_en_i = 1; step("R1 single");
    base_pair(); step("R4 alu+lsu pair");
    base_pair(); b_unit_i = 2'd0; step("R4 same unit");
    base_pair(); b_src0_i = 6'd4; step("R2 src0 raw");
    base_pair(); b_src1_i = 6'd4; step("R2 src1 raw");
    base_pair(); b_src1_i = 6'd4; b_src_en_i = 2'b01; step("R2 src1 disabled");
    base_pair(); b_src0_i = 6'd4; a_wr_en_i = 0; step("R2 a no write");
    base_pair(); a_pset_i = 1; a_pdst_i = 3'd2; b_pidx_i = 3'd2; step("R3 guard dep");
    base_pair(); a_pset_i = 1; a_pdst_i = 3'd3; b_pidx_i = 3'd2; step("R3 other pred");
    base_pair(); a_pset_i = 1; a_pdst_i = 3'd7; b_pidx_i = 3'd7; step("R3 const true");
    base_pair(); b_dst_i = 6'd4; a_pidx_i = 3'd0; b_pidx_i = 3'd0; b_pneg_i = 1;
    step("R6 complementary");
    base_pair(); b_dst_i = 6'd4; a_pidx_i = 3'd0; b_pidx_i = 3'd2; step("R6 overlap");
    base_pair(); b_dst_i = 6'd4; a_pidx_i = 3'd1; b_pidx_i = 3'd1; step("R6 empty masks");
    base_pair(); b_dst_i = 6'd4; b_wr_en_i = 0; step("R7 b no write");
    base_pair(); b_dst_i = 6'd4; a_wr_en_i = 0; step("R7 a no write");
    base_pair(); a_pidx_i = 3'd7; a_pneg_i = 1; b_pidx_i = 3'd2; b_pneg_i = 1;
    step("R5 inverted guards");
    base_pair(); a_valid_i = 0; step("R10 no older");
    base_pair(); b_valid_i = 0; step("R8 no younger");

    for (int i = 0; i < 3000; i++) begin
      pred_file_i = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
      if (i % 5 == 0) pred_file_i[3 * LANES +: LANES] = '0;
      a_valid_i = ($urandom % 8) != 0; b_valid_i = ($urandom % 8) != 0;
      a_dst_i = 6'($urandom % 4); b_dst_i = 6'($urandom % 4);
      a_wr_en_i = ($urandom % 4) != 0; b_wr_en_i = ($urandom % 4) != 0;
      a_unit_i = 2'($urandom); b_unit_i = 2'($urandom);
      a_pidx_i = 3'($urandom); b_pidx_i = 3'($urandom);
      a_pneg_i = 1'($urandom); b_pneg_i = 1'($urandom);
      a_pset_i = 1'($urandom); a_pdst_i = 3'($urandom);
      b_src0_i = 6'($urandom % 8); b_src1_i = 6'($urandom % 8);
      b_src_en_i = 2'($urandom);
      step("R6 random");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #1_000_000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule